// File: doc/BRIEF.md
# Weight-Stationary Systolic MAC Array

A square grid of N×N multiply-accumulate cells that computes the product of a stored N×N weight matrix with a stream of N-element input vectors. Each cell keeps one signed weight. Activations enter from the left and move one column to the right on each clock. Partial sums start at zero at the top of each column, pick up one product per row on the way down, and leave at the bottom. Every cell works on every clock. No cell ever stalls, and operands equal to zero are not skipped.

Weights are loaded through a separate shift path before streaming starts. While the load enable is high, each column shifts its weights one row down, and row 0 takes the value on the weight input. The caller applies the skew: element r of a vector goes on row r exactly r cycles after element 0. A valid flag goes with element 0 and travels through the grid with the data. The flag marks the finished dot product at the bottom of each column. The grid accepts a new vector on every clock.

Top module: `ws_systolic_array`

## Requirements
- R1: While `rst_ni` is low, every activation register, partial-sum register and valid bit is cleared, so `sum_o` reads all zero and `vld_o` reads all zero. Stored weights are not cleared and must be reloaded.
- R2: While `wt_load_i` is low, the stored weights do not change, whatever is driven on `wt_i`.
- R3: An activation driven on row r passes through every column of that row, one column per clock. Each cell of the row multiplies it by that cell's own weight.
- R4: At each clock with `wt_load_i` high, row 0 of column c takes `wt_i[c*8 +: 8]` and every lower row takes the weight the row above held. After N load clocks, row r holds the value presented on load clock N-1-r (counting from 0). Loading must not coincide with `act_vld_i`.
- R5: Suppose element x[r] is driven on `act_i[r*8 +: 8]` at edge e+r. Then after edge e+N-1+c, `sum_o[c*32 +: 32]` equals the sum over r of w[r][c]·x[r].
- R6: `vld_o[c]` is high after edge e+N-1+c exactly when `act_vld_i` was high at edge e. Activations driven at edges with no valid vector do not change any valid result.
- R7: Weights and activations are signed 8-bit two's-complement values. Each column result is a signed 32-bit two's-complement value that wraps on overflow.
- R8: A vector whose elements are zero, wholly or in part, takes the same path and latency as any other vector and produces a valid result.
- R9: Vectors may be issued on consecutive clocks, and each vector produces its own result one clock after the previous vector's result in the same column.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wt_load_i | input | 1 | Weight shift enable |
| wt_i | input | N*W_W | Weight per column entering row 0 (column c at bits c*W_W) |
| act_i | input | N*A_W | Skewed activation per row (row r at bits r*A_W) |
| act_vld_i | input | 1 | Marks a vector whose element 0 is on row 0 this cycle |
| sum_o | output | N*ACC_W | Column result (column c at bits c*ACC_W) |
| vld_o | output | N | Result valid per column |

## Verification
On every clock the assertions check the following: weights stay put outside a load, and each activation moves exactly one column per cycle. The valid bit steps one row down per cycle and lands one cycle later in each column to the right. Loading never overlaps a valid vector. The arithmetic itself is shown only by the bench scenarios, which a reference model checks result by result. These scenarios cover:
- the weight-load order, read back through unit vectors;
- signed extreme operands;
- zero vectors;
- back-to-back streaming with junk on the unused skew slots;
- a reset that lands mid-stream.

// File: rtl/ws_pkg.sv
package ws_pkg;
  parameter int unsigned DEF_N     = 4;
  parameter int unsigned DEF_A_W   = 8;
  parameter int unsigned DEF_W_W   = 8;
  parameter int unsigned DEF_ACC_W = 32;
endpackage

// File: rtl/ws_mac_cell.sv
module ws_mac_cell #(
  parameter int unsigned A_W   = ws_pkg::DEF_A_W,
  parameter int unsigned W_W   = ws_pkg::DEF_W_W,
  parameter int unsigned ACC_W = ws_pkg::DEF_ACC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wt_load_i,
  input  logic [W_W-1:0]   wt_i,
  output logic [W_W-1:0]   wt_o,
  input  logic [A_W-1:0]   act_i,
  output logic [A_W-1:0]   act_o,
  input  logic [ACC_W-1:0] psum_i,
  output logic [ACC_W-1:0] psum_o
);
  localparam int unsigned PW = A_W + W_W;

  logic [W_W-1:0]   wt_q;
  logic [A_W-1:0]   act_q;
  logic [ACC_W-1:0] psum_q;
  logic signed [PW-1:0] prod;
  logic [ACC_W-1:0] prod_ext;

  // weights are not reset: undefined until loaded
  always_ff @(posedge clk_i) begin
    if (wt_load_i) wt_q <= wt_i;
  end

  always_comb begin
    prod     = $signed(act_i) * $signed(wt_q);
    prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      psum_q <= '0;
    end else begin
      act_q  <= act_i;
      psum_q <= psum_i + prod_ext;
    end
  end

  assign wt_o   = wt_q;
  assign act_o  = act_q;
  assign psum_o = psum_q;
endmodule

// File: rtl/ws_vld_grid.sv
module ws_vld_grid #(
  parameter int unsigned N = ws_pkg::DEF_N
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  vld_i,
  output logic [N-1:0][N-1:0]   vld_q_o,
  output logic [N-1:0]          vld_o
);
  localparam int unsigned HW = (N > 1) ? N - 1 : 1;

  logic [HW-1:0]        h_q;
  logic [N-1:0]         h_in;
  logic [N-1:0][N-1:0]  v_q;

  for (genvar c = 0; c < N; c++) begin : g_col
    if (c == 0) begin : g_first
      assign h_in[c] = vld_i;
    end else begin : g_next
      assign h_in[c] = h_q[c-1];
    end
    if (c < N - 1) begin : g_h
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) h_q[c] <= 1'b0;
        else         h_q[c] <= h_in[c];
      end
    end
    for (genvar r = 0; r < N; r++) begin : g_row
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     v_q[r][c] <= 1'b0;
        else if (r == 0) v_q[r][c] <= h_in[c];
        else             v_q[r][c] <= v_q[(r == 0) ? 0 : r-1][c];
      end
    end
    assign vld_o[c] = v_q[N-1][c];
  end

  assign vld_q_o = v_q;
endmodule

// File: rtl/ws_systolic_array.sv
module ws_systolic_array #(
  parameter int unsigned N     = ws_pkg::DEF_N,
  parameter int unsigned A_W   = ws_pkg::DEF_A_W,
  parameter int unsigned W_W   = ws_pkg::DEF_W_W,
  parameter int unsigned ACC_W = ws_pkg::DEF_ACC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wt_load_i,
  input  logic [N*W_W-1:0]   wt_i,
  input  logic [N*A_W-1:0]   act_i,
  input  logic               act_vld_i,
  output logic [N*ACC_W-1:0] sum_o,
  output logic [N-1:0]       vld_o
);
  logic [N-1:0][N-1:0][W_W-1:0]   wt_q;
  logic [N-1:0][N-1:0][A_W-1:0]   act_q;
  logic [N-1:0][N-1:0][ACC_W-1:0] psum_q;
  logic [N-1:0][N-1:0][W_W-1:0]   wt_in;
  logic [N-1:0][N-1:0][A_W-1:0]   act_in;
  logic [N-1:0][N-1:0][ACC_W-1:0] psum_in;
  logic [N-1:0][N-1:0]            vld_q;

  for (genvar r = 0; r < N; r++) begin : g_row
    for (genvar c = 0; c < N; c++) begin : g_col
      if (r == 0) begin : g_top
        assign wt_in[r][c]   = wt_i[c*W_W +: W_W];
        assign psum_in[r][c] = '0;
      end else begin : g_inner
        assign wt_in[r][c]   = wt_q[r-1][c];
        assign psum_in[r][c] = psum_q[r-1][c];
      end
      if (c == 0) begin : g_left
        assign act_in[r][c] = act_i[r*A_W +: A_W];
      end else begin : g_right
        assign act_in[r][c] = act_q[r][c-1];
      end

      ws_mac_cell #(.A_W(A_W), .W_W(W_W), .ACC_W(ACC_W)) i_cell (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wt_load_i (wt_load_i),
        .wt_i      (wt_in[r][c]),
        .wt_o      (wt_q[r][c]),
        .act_i     (act_in[r][c]),
        .act_o     (act_q[r][c]),
        .psum_i    (psum_in[r][c]),
        .psum_o    (psum_q[r][c])
      );
    end
  end

  for (genvar c = 0; c < N; c++) begin : g_out
    assign sum_o[c*ACC_W +: ACC_W] = psum_q[N-1][c];
  end

  ws_vld_grid #(.N(N)) i_vld (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vld_i   (act_vld_i),
    .vld_q_o (vld_q),
    .vld_o   (vld_o)
  );
endmodule

// File: rtl/ws_array_chk.sv
module ws_array_chk #(
  parameter int unsigned N   = ws_pkg::DEF_N,
  parameter int unsigned A_W = ws_pkg::DEF_A_W,
  parameter int unsigned W_W = ws_pkg::DEF_W_W
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         wt_load_i,
  input logic                         act_vld_i,
  input logic [N-1:0]                 vld_o,
  input logic [N-1:0][N-1:0][W_W-1:0] wt_q,
  input logic [N-1:0][N-1:0][A_W-1:0] act_q,
  input logic [N-1:0][N-1:0]          vld_q
);
  AST_LOAD_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wt_load_i |-> !act_vld_i); // R4

  AST_WT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wt_load_i |=> $stable(wt_q)); // R2

  for (genvar r = 0; r < N; r++) begin : g_r
    for (genvar c = 0; c < N - 1; c++) begin : g_c
      AST_ACT_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        act_q[r][c+1] == $past(act_q[r][c])); // R3
    end
  end

  for (genvar c = 0; c < N - 1; c++) begin : g_skew
    AST_VLD_SKEW: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_o[c+1] == $past(vld_o[c])); // R6
  end

  for (genvar r = 0; r < N - 1; r++) begin : g_dr
    for (genvar c = 0; c < N; c++) begin : g_dc
      AST_VLD_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        vld_q[r+1][c] == $past(vld_q[r][c])); // R5
    end
  end
endmodule

bind ws_systolic_array ws_array_chk #(.N(N), .A_W(A_W), .W_W(W_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wt_load_i (wt_load_i),
  .act_vld_i (act_vld_i),
  .vld_o     (vld_o),
  .wt_q      (wt_q),
  .act_q     (act_q),
  .vld_q     (vld_q)
);

// File: tb/test_ws_systolic_array.sv
module test_ws_systolic_array;
  localparam int N = 4, A_W = 8, W_W = 8, ACC_W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int RS = 64;

  logic clk_i = 1'b0, rst_ni = 1'b0, wt_load_i = 1'b0, act_vld_i = 1'b0;
  logic [N*W_W-1:0]   wt_i  = '0;
  logic [N*A_W-1:0]   act_i = '0;
  logic [N*ACC_W-1:0] sum_o;
  logic [N-1:0]       vld_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ws_systolic_array #(.N(N), .A_W(A_W), .W_W(W_W), .ACC_W(ACC_W)) i_ws_systolic_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .wt_load_i(wt_load_i), .wt_i(wt_i),
    .act_i(act_i), .act_vld_i(act_vld_i), .sum_o(sum_o), .vld_o(vld_o));

  int n_chk = 0, n_fail = 0;
  int e = 0;
  int wm[N][N];
  bit hv[RS];
  int hx[RS][N];
  bit ev[RS][N];
  int es[RS][N];
  string tag = "R1";

  function automatic void chk(string t, longint a, longint x, string what);
    n_chk++;
    if (a != x) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, a, x);
    end
  endfunction

  function automatic void clear_model();
    for (int i = 0; i < RS; i++) begin
      hv[i] = 0;
      for (int c = 0; c < N; c++) ev[i][c] = 0;
    end
  endfunction

  // one clock: drive at negedge, compare at the following negedge
  task automatic step(input bit v, input int x[N], input bit ld, input int wv[N]);
    int slot;
    slot = e % RS;
    hv[slot] = v;
    for (int r = 0; r < N; r++) hx[slot][r] = x[r];
    for (int r = 0; r < N; r++) begin
      int k = e - r;
      if (k >= 0 && hv[k % RS]) act_i[r*A_W +: A_W] = A_W'(hx[k % RS][r]);
      else                      act_i[r*A_W +: A_W] = A_W'($urandom);
    end
    if (v) begin
      for (int c = 0; c < N; c++) begin
        int s = 0;
        for (int r = 0; r < N; r++) s += wm[r][c] * x[r];
        ev[(e+N-1+c) % RS][c] = 1;
        es[(e+N-1+c) % RS][c] = s;
      end
    end
    for (int c = 0; c < N; c++) wt_i[c*W_W +: W_W] = W_W'(wv[c]);
    if (ld) begin
      for (int r = N-1; r > 0; r--)
        for (int c = 0; c < N; c++) wm[r][c] = wm[r-1][c];
      for (int c = 0; c < N; c++) wm[0][c] = wv[c];
    end
    wt_load_i = ld;
    act_vld_i = v;
    @(posedge clk_i);
    @(negedge clk_i);
    slot = e % RS;
    for (int c = 0; c < N; c++) begin
      chk("R6", vld_o[c], ev[slot][c], $sformatf("valid col %0d edge %0d", c, e));
      if (ev[slot][c])
        chk(tag, $signed(sum_o[c*ACC_W +: ACC_W]), es[slot][c],
            $sformatf("sum col %0d edge %0d", c, e));
      ev[slot][c] = 0;
    end
    e++;
  endtask

  task automatic idle(input int n);
    int z[N], g[N];
    for (int i = 0; i < n; i++) begin
      for (int r = 0; r < N; r++) begin z[r] = 0; g[r] = $urandom_range(0, 255) - 128; end
      step(0, z, 0, g);
    end
  endtask

  task automatic send(input int x[N]);
    int g[N];
    for (int c = 0; c < N; c++) g[c] = $urandom_range(0, 255) - 128;
    step(1, x, 0, g);
  endtask

  task automatic load(input int w[N][N]);
    int z[N], row[N];
    for (int i = 0; i < N; i++) begin
      for (int c = 0; c < N; c++) begin z[c] = 0; row[c] = w[N-1-i][c]; end
      step(0, z, 1, row);
    end
  endtask

  task automatic send_rand();
    int x[N];
    for (int r = 0; r < N; r++) x[r] = $urandom_range(0, 255) - 128;
    send(x);
  endtask

  task automatic check_reset_outputs();
    for (int c = 0; c < N; c++) begin
      chk("R1", vld_o[c], 0, $sformatf("valid col %0d in reset", c));
      chk("R1", $signed(sum_o[c*ACC_W +: ACC_W]), 0, $sformatf("sum col %0d in reset", c));
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int w[N][N], x[N];
    clear_model();
    repeat (3) @(negedge clk_i);
    check_reset_outputs();
    rst_ni = 1'b1;

    // R4: load random weights, read each row back with unit vectors
    tag = "R4";
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) w[r][c] = $urandom_range(0, 255) - 128;
    load(w);
    for (int r = 0; r < N; r++) begin
      for (int i = 0; i < N; i++) x[i] = (i == r) ? 1 : 0;
      send(x);
    end
    idle(2*N);

    // R5 R9: back-to-back random vectors
    tag = "R5 R9";
    for (int i = 0; i < 8; i++) send_rand();
    idle(2*N);

    // R3: only row 0 active, reused across every column
    tag = "R3";
    for (int i = 0; i < N; i++) x[i] = 0;
    x[0] = -77;
    send(x);
    x[0] = 101;
    send(x);
    idle(2*N);

    // R2: junk on wt_i with load low (send/idle drive random weights)
    tag = "R2";
    for (int i = 0; i < 6; i++) begin send_rand(); idle(1); end
    idle(2*N);

    // R7: signed extremes
    tag = "R7";
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) w[r][c] = ((r + c) % 2 == 0) ? -128 : 127;
    load(w);
    for (int i = 0; i < N; i++) x[i] = -128;
    send(x);
    for (int i = 0; i < N; i++) x[i] = 127;
    send(x);
    for (int i = 0; i < N; i++) x[i] = (i % 2 == 0) ? -128 : 127;
    send(x);
    idle(2*N);

    // R8: zero operands
    tag = "R8";
    for (int i = 0; i < N; i++) x[i] = 0;
    send(x);
    for (int i = 0; i < N; i++) x[i] = (i % 2 == 0) ? 0 : -5;
    send(x);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) w[r][c] = 0;
    idle(2*N);
    load(w);
    send_rand();
    idle(2*N);

    // R1: reset with vectors in flight
    tag = "R1";
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) w[r][c] = $urandom_range(0, 255) - 128;
    load(w);
    send_rand();
    send_rand();
    rst_ni = 1'b0;
    act_vld_i = 1'b0;
    wt_load_i = 1'b0;
    #1;
    check_reset_outputs();
    clear_model();
    @(negedge clk_i);
    check_reset_outputs();
    rst_ni = 1'b1;
    load(w);
    send_rand();
    send_rand();
    idle(2*N);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule